// File: doc/BRIEF.md
# Flash Program/Erase Sequencer

This block writes a stream of bytes into a serial NOR flash through an external byte shifter. Given a start address and a byte count, it first clears every 32 KiB erase block that covers the length, counting offsets up from zero. It then programs the data in page-sized chunks of up to 256 bytes. Every erase and every page is unlocked by its own write-enable frame. After each erase and each page, the block polls status register 1 until the busy flag clears.

The block owns the flash chip select and hands the shifter one byte at a time through a go/done pair. The data arrives on a valid/ready stream, and the block pulls a byte only when a data byte of a page frame is about to be shifted. A quad flag picks the four-line program command. Under that command only the payload bytes travel on four lines; the opcode and address still go out on one line. The operation ends with a one-cycle done pulse, and the error flag is valid in the same cycle.

Top module: `flash_pe_seq`

## Requirements
- R1: A start address whose low 8 bits (the offset within a page) are not all zero ends the operation with done and error high together one cycle after start. Chip select never goes low for that operation.
- R2: A byte count of zero ends the operation with done high and error low one cycle after start, and no frame is sent.
- R3: For each offset 0, ERASE_BYTES, 2*ERASE_BYTES, ... that is below the byte count, the block sends a one-byte frame 0x06 and then a four-byte frame 0x52 followed by the offset as three bytes, most significant first.
- R4: After every erase frame and every page frame, the block sends two-byte status frames {0x05, 0xFF}. It repeats this frame while bit 0 of the byte returned for the second position is 1, and moves on when that bit is 0. The other returned bits are ignored.
- R5: After the erases, each page is a one-byte 0x06 frame followed by a frame made of the program opcode, the 24-bit page address most significant byte first, and min(remaining, 256) data bytes in stream order. Between pages the address rises and the remaining count falls by the bytes sent.
- R6: The program opcode is 0x02 when the quad flag was low at start and 0x32 when it was high. The shifter's quad line is high only for the data bytes of a page frame in quad mode.
- R7: in_ready is high only while a data byte of a page frame is waiting to be issued. Each accepted byte is the next byte passed to the shifter.
- R8: Chip select stays low for a whole frame and goes high for at least one cycle between frames. A new shifter go is issued only after the previous byte's done, and only inside a frame.
- R9: When the last status poll after the last page shows not busy, done pulses for exactly one cycle with error low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (taken when idle) |
| start_addr | input | 24 | First flash byte address to program |
| byte_count | input | CW | Number of bytes to write |
| quad_mode | input | 1 | Use the four-line program command |
| in_data | input | 8 | Stream byte to program |
| in_valid | input | 1 | Stream byte present |
| in_ready | output | 1 | Stream byte accepted this cycle when valid |
| sft_go | output | 1 | Start shifting sft_tx |
| sft_tx | output | 8 | Byte to shift out |
| sft_quad | output | 1 | Shift this byte on four lines |
| sft_done | input | 1 | Shifter finished the byte |
| sft_rx | input | 8 | Byte captured by the shifter |
| flash_cs_n | output | 1 | Flash chip select, active low |
| done | output | 1 | One-cycle end-of-operation pulse |
| error | output | 1 | Operation rejected, valid with done |

## Verification
A wrong offset or stage register shows up at the very next chip-select rise as a frame whose bytes or length differ from the reference list: a skipped erase, a stray poll, or a page address off by a chunk. A wrong byte index in the framer shows within the same frame, either as a missing address byte or as in_ready rising during the header. A wrong busy decision either ends polling early, and the next frame already disagrees, or never ends it, and the run stalls. Every frame is compared as it closes, so no fault of this kind survives more than one frame.

// File: rtl/flash_pe_pkg.sv
package flash_pe_pkg;

  typedef enum logic [1:0] {K_WEN, K_ERASE, K_STAT, K_PROG} frame_kind_t;

  localparam logic [7:0] OP_WEN      = 8'h06;
  localparam logic [7:0] OP_ERASE32  = 8'h52;
  localparam logic [7:0] OP_STATUS1  = 8'h05;
  localparam logic [7:0] OP_PROG_1X  = 8'h02;
  localparam logic [7:0] OP_PROG_4X  = 8'h32;
  localparam logic [7:0] FILL_BYTE   = 8'hFF;
  localparam logic [7:0] BUSY_MASK   = 8'h01;

  // Header byte at positions 0..3 of a frame.
  function automatic logic [7:0] header_byte(frame_kind_t k, logic [1:0] pos,
                                             logic [23:0] a, logic [7:0] prog_op);
    logic [7:0] b;
    case (pos)
      2'd0: begin
        case (k)
          K_WEN:   b = OP_WEN;
          K_ERASE: b = OP_ERASE32;
          K_STAT:  b = OP_STATUS1;
          default: b = prog_op;
        endcase
      end
      2'd1:    b = (k == K_STAT) ? FILL_BYTE : a[23:16];
      2'd2:    b = a[15:8];
      default: b = a[7:0];
    endcase
    return b;
  endfunction

  function automatic logic [7:0] program_opcode(logic quad);
    return quad ? OP_PROG_4X : OP_PROG_1X;
  endfunction

  function automatic logic status_busy(logic [7:0] rx);
    return (rx & BUSY_MASK) != 8'h00;
  endfunction

endpackage

// File: rtl/flash_pe_framer.sv
module flash_pe_framer
  import flash_pe_pkg::*;
#(
  parameter int IW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frm_start,
  input  frame_kind_t   frm_kind,
  input  logic [IW-1:0] frm_len,
  input  logic [23:0]   frm_addr,
  input  logic [7:0]    prog_op,
  input  logic          quad_sel,
  input  logic [7:0]    in_data,
  input  logic          in_valid,
  output logic          in_ready,
  output logic          sft_go,
  output logic [7:0]    sft_tx,
  output logic          sft_quad,
  input  logic          sft_done,
  input  logic [7:0]    sft_rx,
  output logic          cs_n,
  output logic          frm_end,
  output logic [7:0]    frm_rx
);

  typedef enum logic [1:0] {F_IDLE, F_ISSUE, F_WAIT} fstate_t;

  fstate_t       st;
  logic [IW-1:0] idx;
  logic          is_data;
  logic          last_byte;

  assign is_data   = (frm_kind == K_PROG) && (idx >= IW'(4));
  assign last_byte = (idx == frm_len - IW'(1));
  assign in_ready  = (st == F_ISSUE) && is_data;
  assign sft_go    = (st == F_ISSUE) && (!is_data || in_valid);
  assign sft_tx    = is_data ? in_data : header_byte(frm_kind, idx[1:0], frm_addr, prog_op);
  assign sft_quad  = is_data && quad_sel;
  assign cs_n      = (st == F_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= F_IDLE;
      idx     <= '0;
      frm_end <= 1'b0;
      frm_rx  <= 8'h00;
    end else begin
      frm_end <= 1'b0;
      case (st)
        F_IDLE: if (frm_start) begin
          st  <= F_ISSUE;
          idx <= '0;
        end
        F_ISSUE: if (sft_go) st <= F_WAIT;
        default: if (sft_done) begin
          frm_rx <= sft_rx;
          if (last_byte) begin
            st      <= F_IDLE;
            frm_end <= 1'b1;
          end else begin
            idx <= idx + IW'(1);
            st  <= F_ISSUE;
          end
        end
      endcase
    end
  end

  // R8: a byte is in flight until its done; no second go right after one
  p_single_flight_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sft_go |=> !sft_go);

endmodule

// File: rtl/flash_pe_planner.sv
module flash_pe_planner
  import flash_pe_pkg::*;
#(
  parameter int CW          = 24,
  parameter int PAGE_BYTES  = 256,
  parameter int ERASE_BYTES = 32768,
  parameter int IW          = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [23:0]   start_addr,
  input  logic [CW-1:0] byte_count,
  input  logic          quad_mode,
  input  logic          frm_end,
  input  logic [7:0]    frm_rx,
  output logic          frm_start,
  output frame_kind_t   frm_kind,
  output logic [IW-1:0] frm_len,
  output logic [23:0]   frm_addr,
  output logic [7:0]    prog_op,
  output logic          quad_sel,
  output logic          done,
  output logic          error
);

  localparam int PAGE_LG = $clog2(PAGE_BYTES);
  localparam logic [CW:0] ERASE_STEP = (CW+1)'(ERASE_BYTES);

  typedef enum logic {P_IDLE, P_RUN} pstate_t;

  function automatic logic [IW-1:0] page_chunk(logic [CW-1:0] left);
    return (left >= CW'(PAGE_BYTES)) ? IW'(PAGE_BYTES) : IW'(left);
  endfunction

  function automatic logic [IW-1:0] frame_length(frame_kind_t k, logic [CW-1:0] left);
    case (k)
      K_WEN:   return IW'(1);
      K_STAT:  return IW'(2);
      K_ERASE: return IW'(4);
      default: return IW'(4) + page_chunk(left);
    endcase
  endfunction

  pstate_t       pst;
  frame_kind_t   kind;
  logic          stage_prog;
  logic [CW:0]   eoff;
  logic [CW-1:0] rem;
  logic [CW-1:0] cnt;
  logic [23:0]   paddr;
  logic          quad_q, start_q, done_q, err_q;

  // named events
  logic          ev_accept, ev_misaligned, ev_empty;
  logic          ev_poll_busy, ev_poll_clear, ev_erase_more, ev_last_page;
  logic [IW-1:0] chunk_now;

  assign chunk_now     = page_chunk(rem);
  assign ev_accept     = (pst == P_IDLE) && start && !done_q;
  assign ev_misaligned = start_addr[PAGE_LG-1:0] != '0;
  assign ev_empty      = byte_count == '0;
  assign ev_poll_busy  = frm_end && (kind == K_STAT) && status_busy(frm_rx);
  assign ev_poll_clear = frm_end && (kind == K_STAT) && !status_busy(frm_rx);
  assign ev_erase_more = (eoff + ERASE_STEP) < {1'b0, cnt};
  assign ev_last_page  = rem == CW'(chunk_now);

  assign frm_start = start_q;
  assign frm_kind  = kind;
  assign frm_len   = frame_length(kind, rem);
  assign frm_addr  = stage_prog ? paddr : 24'(eoff);
  assign prog_op   = program_opcode(quad_q);
  assign quad_sel  = quad_q;
  assign done      = done_q;
  assign error     = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pst        <= P_IDLE;
      kind       <= K_WEN;
      stage_prog <= 1'b0;
      eoff       <= '0;
      rem        <= '0;
      cnt        <= '0;
      paddr      <= '0;
      quad_q     <= 1'b0;
      start_q    <= 1'b0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      start_q <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      if (ev_accept) begin
        paddr      <= start_addr;
        cnt        <= byte_count;
        rem        <= byte_count;
        quad_q     <= quad_mode;
        eoff       <= '0;
        stage_prog <= 1'b0;
        kind       <= K_WEN;
        if (ev_misaligned) begin
          done_q <= 1'b1;
          err_q  <= 1'b1;
        end else if (ev_empty) begin
          done_q <= 1'b1;
        end else begin
          pst     <= P_RUN;
          start_q <= 1'b1;
        end
      end else if (pst == P_RUN && frm_end) begin
        case (kind)
          K_WEN: begin
            kind    <= stage_prog ? K_PROG : K_ERASE;
            start_q <= 1'b1;
          end
          K_ERASE, K_PROG: begin
            kind    <= K_STAT;
            start_q <= 1'b1;
          end
          default: begin
            if (ev_poll_busy) begin
              start_q <= 1'b1;
            end else if (!stage_prog) begin
              kind    <= K_WEN;
              start_q <= 1'b1;
              if (ev_erase_more) eoff <= eoff + ERASE_STEP;
              else               stage_prog <= 1'b1;
            end else begin
              rem   <= rem - CW'(chunk_now);
              paddr <= paddr + 24'(chunk_now);
              if (ev_last_page) begin
                pst    <= P_IDLE;
                done_q <= 1'b1;
              end else begin
                kind    <= K_WEN;
                start_q <= 1'b1;
              end
            end
          end
        endcase
      end
    end
  end

  // R9: done lasts one cycle
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4: every erase or page frame is followed by a status poll
  p_poll_after_op_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_end && (kind == K_ERASE || kind == K_PROG)) |=> (frm_start && kind == K_STAT));

  // R4: a busy reply repeats the status frame
  p_repoll_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_poll_busy |=> (frm_start && kind == K_STAT));

  // R2: a finished operation that did not fail returned to idle
  p_clean_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !error) |-> pst == P_IDLE);

endmodule

// File: rtl/flash_pe_seq.sv
module flash_pe_seq
  import flash_pe_pkg::*;
#(
  parameter int CW          = 24,
  parameter int PAGE_BYTES  = 256,
  parameter int ERASE_BYTES = 32768
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [23:0]   start_addr,
  input  logic [CW-1:0] byte_count,
  input  logic          quad_mode,
  input  logic [7:0]    in_data,
  input  logic          in_valid,
  output logic          in_ready,
  output logic          sft_go,
  output logic [7:0]    sft_tx,
  output logic          sft_quad,
  input  logic          sft_done,
  input  logic [7:0]    sft_rx,
  output logic          flash_cs_n,
  output logic          done,
  output logic          error
);

  localparam int IW = $clog2(PAGE_BYTES + 5);

  logic          frm_start, frm_end, quad_sel;
  frame_kind_t   frm_kind;
  logic [IW-1:0] frm_len;
  logic [23:0]   frm_addr;
  logic [7:0]    prog_op, frm_rx;

  flash_pe_planner #(
    .CW(CW), .PAGE_BYTES(PAGE_BYTES), .ERASE_BYTES(ERASE_BYTES), .IW(IW)
  ) u_plan (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .byte_count(byte_count), .quad_mode(quad_mode), .frm_end(frm_end),
    .frm_rx(frm_rx), .frm_start(frm_start), .frm_kind(frm_kind),
    .frm_len(frm_len), .frm_addr(frm_addr), .prog_op(prog_op),
    .quad_sel(quad_sel), .done(done), .error(error)
  );

  flash_pe_framer #(.IW(IW)) u_frame (
    .clk(clk), .rst_n(rst_n), .frm_start(frm_start), .frm_kind(frm_kind),
    .frm_len(frm_len), .frm_addr(frm_addr), .prog_op(prog_op),
    .quad_sel(quad_sel), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .sft_go(sft_go), .sft_tx(sft_tx),
    .sft_quad(sft_quad), .sft_done(sft_done), .sft_rx(sft_rx),
    .cs_n(flash_cs_n), .frm_end(frm_end), .frm_rx(frm_rx)
  );

  // R6: four-line shifting only on page payload
  p_quad_payload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sft_go && sft_quad) |-> (frm_kind == K_PROG && prog_op == OP_PROG_4X));

  // R7: stream is pulled only inside a page frame
  p_ready_in_page_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (frm_kind == K_PROG && !flash_cs_n));

  // R8: shifter starts only inside a frame
  p_go_in_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sft_go |-> !flash_cs_n);

  // R8: chip select stays high at least one full cycle between frames
  p_cs_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flash_cs_n) |=> flash_cs_n);

  // R1: error appears only with done
  p_err_with_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> done);

  // R1: a rejected operation never opened a frame
  p_reject_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (done && error) |-> (flash_cs_n && $past(flash_cs_n)));

endmodule

// File: tb/flash_pe_seq_test.sv
module flash_pe_seq_test;

  localparam int CW    = 24;
  localparam int ERASE = 1024;
  localparam int LAT   = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [23:0]   start_addr = '0;
  logic [CW-1:0] byte_count = '0;
  logic          quad_mode = 1'b0;
  logic [7:0]    in_data = 8'h00;
  logic          in_valid = 1'b0;
  logic          in_ready, sft_go, sft_quad, flash_cs_n, done, error;
  logic [7:0]    sft_tx;
  logic          sft_done = 1'b0;
  logic [7:0]    sft_rx = 8'hFF;

  always #4 clk = ~clk;

  flash_pe_seq #(.CW(CW), .PAGE_BYTES(256), .ERASE_BYTES(ERASE)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .byte_count(byte_count), .quad_mode(quad_mode), .in_data(in_data),
    .in_valid(in_valid), .in_ready(in_ready), .sft_go(sft_go),
    .sft_tx(sft_tx), .sft_quad(sft_quad), .sft_done(sft_done),
    .sft_rx(sft_rx), .flash_cs_n(flash_cs_n), .done(done), .error(error)
  );

  int checks = 0, fails = 0, cyc = 0;
  logic [7:0] exp_b[$];
  int         exp_len[$];
  logic [7:0] dq[$];
  logic [7:0] cur[$];
  logic       curq[$];
  int  lat = 0, busy_left = 0, busy_set = 0, frames_seen = 0, high_cnt = 0;
  logic [7:0] rx_next = 8'hFF;
  bit  pop_pending = 0, gaps = 0, prev_cs = 1, prev_done = 0;
  bit  done_seen = 0, err_seen = 0;

  task automatic check(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // drive phase, just after each rising edge
  always @(posedge clk) begin
    #1;
    if (pop_pending) begin
      void'(dq.pop_front());
      pop_pending = 0;
    end
    in_data  = (dq.size() > 0) ? dq[0] : 8'h00;
    in_valid = (dq.size() > 0) && (!gaps || (cyc % 3) != 1);
    sft_done = 1'b0;
    if (lat > 0) begin
      lat--;
      if (lat == 0) begin
        sft_done = 1'b1;
        sft_rx   = rx_next;
      end
    end
  end

  // observe phase, on falling edges
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (in_ready) begin
        check(!flash_cs_n && cur.size() >= 4 && (cur[0] == 8'h02 || cur[0] == 8'h32),
              "R7", "ready outside page payload", cur.size(), 4);
        if (in_valid) pop_pending = 1;
      end
      if (sft_go) begin
        check(!flash_cs_n && lat == 0, "R8", "go outside frame or overlapping", lat, 0);
        if (cur.size() == 1 && cur[0] == 8'h05)
          begin
            rx_next = (busy_left > 0) ? 8'hFD : 8'hFE;
            if (busy_left > 0) busy_left--;
          end
        else rx_next = 8'hFF;
        cur.push_back(sft_tx);
        curq.push_back(sft_quad);
        lat = LAT;
      end
      if (prev_cs && !flash_cs_n && frames_seen > 0)
        check(high_cnt >= 1, "R8", "no gap between frames", high_cnt, 1);
      high_cnt = flash_cs_n ? high_cnt + 1 : 0;
      if (!prev_cs && flash_cs_n) begin
        compare_frame();
        frames_seen++;
      end
      if (done) begin
        check(!prev_done, "R9", "done longer than one cycle", 1, 0);
        done_seen = 1;
        err_seen  = error;
      end
    end
    prev_cs   = flash_cs_n;
    prev_done = done;
  end

  task automatic compare_frame();
    int n;
    string req;
    bit ok, qok;
    n = (exp_len.size() > 0) ? exp_len.pop_front() : 0;
    req = "R8";
    if (n > 0)
      case (exp_b[0])
        8'h52: req = "R3";
        8'h05: req = "R4";
        8'h02, 8'h32: req = "R5";
        default: req = "R8";
      endcase
    ok  = (n == cur.size());
    qok = 1;
    for (int i = 0; i < n; i++) begin
      logic [7:0] e;
      e = exp_b.pop_front();
      if (i < cur.size()) begin
        if (cur[i] != e) begin
          if (ok) $display("  frame byte %0d differs: %0h vs %0h", i, cur[i], e);
          ok = 0;
        end
        if (curq[i] != (cur[0] == 8'h32 && i >= 4)) qok = 0;
      end
    end
    check(ok, req, "frame content/length", cur.size(), n);
    check(qok, "R6", "quad flag on wrong byte", 0, 1);
    if (cur.size() > 0 && (cur[0] == 8'h52 || cur[0] == 8'h02 || cur[0] == 8'h32))
      busy_left = busy_set;
    cur.delete();
    curq.delete();
  endtask

  task automatic push_frame(logic [7:0] b[$]);
    foreach (b[i]) exp_b.push_back(b[i]);
    exp_len.push_back(b.size());
  endtask

  task automatic run(int addr, int count, bit quad, bit gp, int busy, bit exp_err, string req);
    int off, left, a, k, waited;
    logic [7:0] data[$];
    logic [7:0] f[$];
    for (int i = 0; i < count; i++) data.push_back(8'((i * 13 + count + 5) & 255));
    if (!exp_err) begin
      for (off = 0; off < count; off += ERASE) begin
        push_frame('{8'h06});
        push_frame('{8'h52, 8'(off >> 16), 8'(off >> 8), 8'(off)});
        for (int p = 0; p <= busy; p++) push_frame('{8'h05, 8'hFF});
      end
      left = count; a = addr; k = 0;
      while (left > 0) begin
        int n;
        n = (left > 256) ? 256 : left;
        push_frame('{8'h06});
        f.delete();
        f.push_back(quad ? 8'h32 : 8'h02);
        f.push_back(8'(a >> 16)); f.push_back(8'(a >> 8)); f.push_back(8'(a));
        for (int i = 0; i < n; i++) f.push_back(data[k + i]);
        push_frame(f);
        for (int p = 0; p <= busy; p++) push_frame('{8'h05, 8'hFF});
        left -= n; a += n; k += n;
      end
      foreach (data[i]) dq.push_back(data[i]);
    end
    gaps = gp; busy_set = busy; busy_left = 0;
    frames_seen = 0; done_seen = 0; err_seen = 0;
    @(posedge clk); #1;
    start = 1; start_addr = 24'(addr); byte_count = CW'(count); quad_mode = quad;
    @(posedge clk); #1;
    start = 0;
    waited = 0;
    while (!done_seen && waited < 60000) begin
      @(negedge clk); waited++;
    end
    #2;
    check(done_seen, req, "done seen", done_seen, 1);
    check(err_seen == exp_err, exp_err ? "R1" : "R9", "error flag", err_seen, exp_err);
    check(exp_len.size() == 0, req, "frames left unsent", exp_len.size(), 0);
    check(dq.size() == 0, "R7", "stream bytes left", dq.size(), 0);
    if (exp_err || count == 0)
      check(frames_seen == 0, req, "frames sent", frames_seen, 0);
    exp_b.delete(); exp_len.delete(); dq.delete();
    repeat (3) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check(flash_cs_n && !done && !error && !in_ready && !sft_go, "R8", "reset state",
          {flash_cs_n, done, error, in_ready, sft_go}, 5'b10000);
    run(24'h000105, 10, 0, 0, 0, 1, "R1");
    run(24'h000080, 600, 1, 0, 0, 1, "R1");
    run(24'h000300, 0, 0, 0, 0, 0, "R2");
    run(24'h001200, 300, 0, 0, 2, 0, "R5");
    run(24'h020000, 1300, 1, 1, 0, 0, "R3");
    run(24'h004000, 256, 1, 0, 1, 0, "R6");
    run(24'h000000, 1025, 0, 1, 3, 0, "R4");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule